// File: doc/BRIEF.md
# Tiled Address Bit-6 Swizzler

This unit converts a byte address produced on the processor side into the address a tiled graphics engine expects when memory is interleaved across two channels. Interleaving steers each 64-byte block to the other channel whenever address bit 6 toggles. Tiled surfaces are walked in two dimensions, so higher address bits are folded into bit 6 by XOR. The bits that are folded in depend on the tiling direction and on how the memory is populated.

A descriptor register holds the memory setup. It records the channel arrangement, whether the processor-side channel XOR is switched off, whether that XOR takes bit 17 instead of bit 11, and whether both channels carry the same amount of memory. From this descriptor the unit derives one swizzle mode for X tiling and one for Y tiling. Each request carries an address and a tiling direction. One cycle later the unit returns the swizzled address, a mode code for software, and a flag that marks a tiled request that had to fall back to linear.

Top module: `swz_bit6_top`

## Requirements
- R1: Every result is registered. `out_valid` equals `in_valid` from the previous clock, and the address, mode and flag outputs belong to the request sampled on that clock.
- R2: Tiling code 0 (linear) and the reserved code 3 pass the address through unchanged, with `out_mode` = 0 and `out_forbid` = 0. Codes 1 and 2 mean X and Y tiling.
- R3: With descriptor bits [1:0] = 2 (interleaved dual channel) and bit 2 set (channel XOR off), X tiling flips bit 6 by bit 9 XOR bit 10 and reports mode 2. Y tiling flips bit 6 by bit 9 and reports mode 1.
- R4: With bits [1:0] = 2, bit 2 clear and bit 3 clear, bit 11 is added to the fold. X reports mode 4 (bits 9, 10, 11) and Y reports mode 3 (bits 9, 11).
- R5: With bits [1:0] = 2, bit 2 clear and bit 3 set, bit 17 is added to the fold applied to the address. The reported mode hides bit 17: X reports 2 and Y reports 1.
- R6: Bits [1:0] = 0 (single channel) or 1 (asymmetric dual channel) apply no swizzle in either direction, and the mode is 0.
- R7: With bits [1:0] = 3 (flexible population), bit 4 set (equal channel sizes) gives the R3 behaviour. Bit 4 clear gives no swizzle and mode 0.
- R8: A descriptor of all ones is unreadable and makes the mode unknown. A tiled request then leaves with the address unchanged, `out_mode` = 0 and `out_forbid` = 1.
- R9: The descriptor resets to 0. A write takes effect for requests sampled on clocks after the write clock. A request sampled on the same clock as the write uses the old value.
- R10: The output address never differs from the input address in any bit other than bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the memory descriptor |
| cfg_wdata | input | CFG_W | Descriptor value to write |
| in_valid | input | 1 | Request valid |
| in_addr | input | ADDR_W | Processor-side byte address |
| in_tile | input | 2 | Tiling direction: 0 linear, 1 X, 2 Y, 3 linear |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_addr | output | ADDR_W | Swizzled byte address |
| out_mode | output | 3 | Swizzle mode reported to software |
| out_forbid | output | 1 | Tiled request downgraded to linear |

## Verification
The bench builds the unit with ADDR_W = 32 and CFG_W = 32. With those widths, bit 17 is a real address bit, so the bit-17 fold of R5 changes the output address and is not cut away by the generate branch. An all-ones 32-bit descriptor also reaches the unknown path of R8. Addresses are chosen to cover every combination of bits 9, 10, 11 and 17. Descriptor writes are placed both beside a request on the same clock and before it, which exposes the timing edge of R9.

// File: rtl/swz_pkg.sv
package swz_pkg;

  typedef enum logic [2:0] {
    SW_NONE     = 3'd0,
    SW_9        = 3'd1,
    SW_9_10     = 3'd2,
    SW_9_11     = 3'd3,
    SW_9_10_11  = 3'd4,
    SW_9_17     = 3'd5,
    SW_9_10_17  = 3'd6,
    SW_UNKNOWN  = 3'd7
  } swz_mode_e;

  typedef enum logic [1:0] {
    TL_LINEAR = 2'd0,
    TL_X      = 2'd1,
    TL_Y      = 2'd2,
    TL_RSVD   = 2'd3
  } tile_e;

  typedef enum logic [1:0] {
    CH_SINGLE    = 2'd0,
    CH_DUAL_ASYM = 2'd1,
    CH_DUAL_ILV  = 2'd2,
    CH_FLEX      = 2'd3
  } chan_e;

  // Low five descriptor bits; everything above is reserved
  typedef struct packed {
    logic  sizes_eq;
    logic  xor_sel17;
    logic  xor_off;
    chan_e chan;
  } cfg_fields_t;

  localparam int CFG_FIELD_W = $bits(cfg_fields_t);

  typedef struct packed {
    swz_mode_e x;
    swz_mode_e y;
  } mode_pair_t;

  function automatic mode_pair_t decode_cfg(cfg_fields_t f, logic unreadable);
    mode_pair_t p;
    p.x = SW_NONE;
    p.y = SW_NONE;
    if (unreadable) begin
      p.x = SW_UNKNOWN;
      p.y = SW_UNKNOWN;
    end else begin
      case (f.chan)
        CH_DUAL_ILV: begin
          if (f.xor_off) begin
            p.x = SW_9_10;
            p.y = SW_9;
          end else if (!f.xor_sel17) begin
            p.x = SW_9_10_11;
            p.y = SW_9_11;
          end else begin
            p.x = SW_9_10_17;
            p.y = SW_9_17;
          end
        end
        CH_FLEX: begin
          if (f.sizes_eq) begin
            p.x = SW_9_10;
            p.y = SW_9;
          end
        end
        default: begin
          p.x = SW_NONE;
          p.y = SW_NONE;
        end
      endcase
    end
    return p;
  endfunction

  function automatic swz_mode_e hide_bit17(swz_mode_e m);
    case (m)
      SW_9_17:    return SW_9;
      SW_9_10_17: return SW_9_10;
      default:    return m;
    endcase
  endfunction

  function automatic logic fold_term(swz_mode_e m, logic b9, logic b10,
                                     logic b11, logic b17);
    logic use9, use10, use11, use17;
    use9  = (m != SW_NONE) && (m != SW_UNKNOWN);
    use10 = (m == SW_9_10) || (m == SW_9_10_11) || (m == SW_9_10_17);
    use11 = (m == SW_9_11) || (m == SW_9_10_11);
    use17 = (m == SW_9_17) || (m == SW_9_10_17);
    return (use9 & b9) ^ (use10 & b10) ^ (use11 & b11) ^ (use17 & b17);
  endfunction

endpackage

// File: rtl/swz_cfg_reg.sv
module swz_cfg_reg
  import swz_pkg::*;
#(
  parameter int CFG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  output swz_mode_e        mode_x,
  output swz_mode_e        mode_y
);
  localparam logic [CFG_W-1:0] ALL_ONES = {CFG_W{1'b1}};

  logic [CFG_W-1:0] cfg_q;
  cfg_fields_t      fields;
  logic             unreadable;
  mode_pair_t       pair;

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_q <= '0;
    else if (wr_en) cfg_q <= wr_data;
  end

  assign fields     = cfg_fields_t'(cfg_q[CFG_FIELD_W-1:0]);
  assign unreadable = (cfg_q == ALL_ONES);
  assign pair       = decode_cfg(fields, unreadable);
  assign mode_x     = pair.x;
  assign mode_y     = pair.y;
endmodule

// File: rtl/swz_mode_pick.sv
module swz_mode_pick
  import swz_pkg::*;
(
  input  logic [1:0] tile,
  input  swz_mode_e  mode_x,
  input  swz_mode_e  mode_y,
  output swz_mode_e  eff_mode,
  output logic       forbid
);
  swz_mode_e chosen;

  always_comb begin
    case (tile_e'(tile))
      TL_X:    chosen = mode_x;
      TL_Y:    chosen = mode_y;
      default: chosen = SW_NONE;
    endcase
  end

  assign forbid   = (chosen == SW_UNKNOWN);
  assign eff_mode = forbid ? SW_NONE : chosen;
endmodule

// File: rtl/swz_addr_xor.sv
module swz_addr_xor
  import swz_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr_in,
  input  swz_mode_e         mode,
  output logic [ADDR_W-1:0] addr_out,
  output logic              flip
);
  localparam bit HAS_B11 = (ADDR_W > 11);
  localparam bit HAS_B17 = (ADDR_W > 17);

  logic b9, b10, b11, b17;

  assign b9  = addr_in[9];
  assign b10 = addr_in[10];

  generate
    if (HAS_B11) begin : g_b11
      assign b11 = addr_in[11];
    end else begin : g_no_b11
      assign b11 = 1'b0;
    end
    if (HAS_B17) begin : g_b17
      assign b17 = addr_in[17];
    end else begin : g_no_b17
      assign b17 = 1'b0;
    end
  endgenerate

  assign flip = fold_term(mode, b9, b10, b11, b17);

  always_comb begin
    addr_out    = addr_in;
    addr_out[6] = addr_in[6] ^ flip;
  end
endmodule

// File: rtl/swz_bit6_top.sv
module swz_bit6_top
  import swz_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CFG_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [1:0]        in_tile,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic [2:0]        out_mode,
  output logic              out_forbid
);
  swz_mode_e         mode_x, mode_y;
  swz_mode_e         eff_mode;
  logic              forbid_now;
  logic              swz_flip;
  logic [ADDR_W-1:0] addr_next;
  swz_mode_e         report_mode;

  swz_cfg_reg #(.CFG_W(CFG_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .wr_data (cfg_wdata),
    .mode_x  (mode_x),
    .mode_y  (mode_y)
  );

  swz_mode_pick u_pick (
    .tile     (in_tile),
    .mode_x   (mode_x),
    .mode_y   (mode_y),
    .eff_mode (eff_mode),
    .forbid   (forbid_now)
  );

  swz_addr_xor #(.ADDR_W(ADDR_W)) u_xor (
    .addr_in  (in_addr),
    .mode     (eff_mode),
    .addr_out (addr_next),
    .flip     (swz_flip)
  );

  assign report_mode = hide_bit17(eff_mode);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_addr   <= '0;
      out_mode   <= 3'd0;
      out_forbid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_addr   <= addr_next;
        out_mode   <= report_mode;
        out_forbid <= forbid_now;
      end
    end
  end
endmodule

// File: rtl/swz_bit6_chk.sv
module swz_bit6_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [ADDR_W-1:0] in_addr,
  input logic [1:0]        in_tile,
  input logic              out_valid,
  input logic [ADDR_W-1:0] out_addr,
  input logic [2:0]        out_mode,
  input logic              out_forbid
);
  localparam logic [ADDR_W-1:0] KEEP_MASK = ~(ADDR_W'(1) << 6);

  logic past_ok;
  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R1
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (out_valid == $past(in_valid)));

  // R10
  only_bit6_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && out_valid) |-> (((out_addr ^ $past(in_addr)) & KEEP_MASK) == '0));

  // R2
  linear_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && out_valid && (($past(in_tile) == 2'd0) || ($past(in_tile) == 2'd3)))
      |-> (out_addr == $past(in_addr) && out_mode == 3'd0 && !out_forbid));

  // R5
  hidden17_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_mode < 3'd5));

  // R8
  forbid_linear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && out_valid && out_forbid) |-> (out_mode == 3'd0 && out_addr == $past(in_addr)));
endmodule

bind swz_bit6_top swz_bit6_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_addr    (in_addr),
  .in_tile    (in_tile),
  .out_valid  (out_valid),
  .out_addr   (out_addr),
  .out_mode   (out_mode),
  .out_forbid (out_forbid)
);

// File: tb/swz_bit6_top_tb.sv
`timescale 1ns/1ps
module swz_bit6_top_tb;
  localparam int AW = 32;
  localparam int CW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [CW-1:0] cfg_wdata = '0;
  logic          in_valid = 1'b0;
  logic [AW-1:0] in_addr = '0;
  logic [1:0]    in_tile = 2'd0;
  logic          out_valid;
  logic [AW-1:0] out_addr;
  logic [2:0]    out_mode;
  logic          out_forbid;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  bit [31:0] model_cfg = 32'h0;

  always #10 clk = ~clk;

  swz_bit6_top #(.ADDR_W(AW), .CFG_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .in_valid(in_valid), .in_addr(in_addr), .in_tile(in_tile),
    .out_valid(out_valid), .out_addr(out_addr), .out_mode(out_mode),
    .out_forbid(out_forbid)
  );

  // Internal mode number: 0 none, 1..6 folds, 7 unknown
  function automatic int ref_raw(bit [31:0] c, int t);
    if (t == 0 || t == 3) return 0;
    if (c == 32'hFFFF_FFFF) return 7;
    case (c & 3)
      2: begin
        if (c[2])       return (t == 1) ? 2 : 1;
        else if (!c[3]) return (t == 1) ? 4 : 3;
        else            return (t == 1) ? 6 : 5;
      end
      3: return c[4] ? ((t == 1) ? 2 : 1) : 0;
      default: return 0;
    endcase
  endfunction

  function automatic string ref_tag(bit [31:0] c, int t);
    if (t == 0 || t == 3) return "R2";
    if (c == 32'hFFFF_FFFF) return "R8";
    if ((c & 3) < 2) return "R6";
    if ((c & 3) == 3) return c[4] ? "R7" : "R7";
    if (c[2]) return "R3";
    return c[3] ? "R5" : "R4";
  endfunction

  function automatic bit [31:0] ref_addr(bit [31:0] a, int raw);
    bit f = 0;
    if (raw >= 1 && raw <= 6) f ^= a[9];
    if (raw == 2 || raw == 4 || raw == 6) f ^= a[10];
    if (raw == 3 || raw == 4) f ^= a[11];
    if (raw == 5 || raw == 6) f ^= a[17];
    return a ^ (32'(f) << 6);
  endfunction

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Drive one cycle at a negedge, check the result at the next negedge
  task automatic cycle(bit v, bit [31:0] a, int t, bit we, bit [31:0] wd, string tag_in);
    int raw;
    string tag;
    bit [31:0] ea;
    int em;
    raw = ref_raw(model_cfg, t);
    tag = (tag_in != "") ? tag_in : ref_tag(model_cfg, t);
    ea  = (raw == 7) ? a : ref_addr(a, raw);
    em  = (raw == 5) ? 1 : (raw == 6) ? 2 : (raw == 7) ? 0 : raw;
    in_valid = v; in_addr = a; in_tile = 2'(t);
    cfg_we = we; cfg_wdata = wd;
    if (we) model_cfg = wd;
    @(negedge clk);
    check(out_valid == v, "R1", "out_valid", out_valid, v);
    if (v) begin
      check(out_addr == ea, tag, "out_addr", out_addr, ea);
      check(out_mode == 3'(em), tag, "out_mode", out_mode, em);
      check(out_forbid == (raw == 7), tag, "out_forbid", out_forbid, (raw == 7));
      check(((out_addr ^ a) & ~32'h40) == 0, "R10", "upper bits", out_addr, a);
    end
  endtask

  task automatic sweep(bit [31:0] c);
    cycle(1'b0, 32'h0, 0, 1'b1, c, "R9");
    for (int t = 0; t < 4; t++) begin
      for (int i = 0; i < 16; i++) begin
        bit [31:0] a;
        a = ($urandom & ~32'h0002_0E00) | (32'(i[0]) << 9) | (32'(i[1]) << 10)
            | (32'(i[2]) << 11) | (32'(i[3]) << 17);
        cycle(1'b1, a, t, 1'b0, 32'h0, "");
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 0 && out_addr == 0 && out_mode == 0 && out_forbid == 0,
          "R1", "reset outputs", {out_valid, out_mode, out_forbid}, 0);
    rst_n = 1'b1;
    // R9: reset descriptor is single channel, no swizzle
    cycle(1'b1, 32'h0000_0600, 1, 1'b0, 32'h0, "R9");
    sweep(32'h0000_0006);          // R3 interleaved, XOR off
    sweep(32'h0000_0002);          // R4 bit 11 added
    sweep(32'h0000_000A);          // R5 bit 17 added, hidden
    sweep(32'h0000_0000);          // R6 single
    sweep(32'h0000_001D);          // R6 asymmetric (upper bits ignored)
    sweep(32'h0000_0013);          // R7 flexible equal
    sweep(32'h0000_0003);          // R7 flexible unequal
    sweep(32'hFFFF_FFFF);          // R8 unreadable
    // R9: write beside a request uses the old value, next request the new one
    cycle(1'b1, 32'h0000_0200, 1, 1'b1, 32'h0000_0006, "R9");
    cycle(1'b1, 32'h0000_0200, 1, 1'b0, 32'h0, "R9");
    cycle(1'b1, 32'h0000_0600, 2, 1'b1, 32'h0000_0000, "R9");
    cycle(1'b1, 32'h0000_0600, 2, 1'b0, 32'h0, "R9");
    // R1: idle cycles
    cycle(1'b0, 32'h0, 1, 1'b0, 32'h0, "R1");
    cycle(1'b0, 32'h0, 2, 1'b0, 32'h0, "R1");
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule